// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block sits on an 8-bit video byte stream in the pixel-clock domain and recovers line and frame timing from four-byte reference codes carried inside the data, so no separate horizontal or vertical sync pins are needed. Each code is a fixed three-byte preamble (`FF`, `00`, `00` in hex) followed by a status byte. The status byte tells whether the code opens or closes an active region and whether the line belongs to vertical blanking.

From these codes the decoder produces a pixel data/valid pair carrying only active-video bytes. It also produces a start-of-line pulse, a start-of-frame pulse, and a one-cycle event pulse for every reference code it recognises. A byte is taken on a clock edge only while the enable input is high. A frame start is only declared once at least one vertical-blanking code has been seen, and no pixels leave the block before the first frame start after reset.

Top module: `evd_stream_decoder`

## Requirements
- R1: A byte is consumed only on a rising clock edge where `en_i` is 1. A cycle following an edge with `en_i` at 0 shows `pix_valid_o`, `sol_o`, `sof_o` and `delim_evt_o` all at 0, and the decoding state is left unchanged.
- R2: A reference code is four consecutive consumed bytes `FF`, `00`, `00`, S, where bit 7 of S is 1. In S, bit 5 = 1 marks vertical blanking and bit 4 selects end of active video (1) or start (0). Bit 6 (field) and bits 3..0 do not affect decoding.
- R3: `delim_evt_o` pulses high for exactly one cycle, in the cycle after the edge that consumed the status byte S. This happens for every recognised code, including blanking codes and codes seen before lock.
- R4: A partial preamble that is broken by any other byte is dropped. If the breaking byte is `FF`, it starts a new preamble, so `FF FF 00 00 S` is a code. A fourth byte with bit 7 at 0 is not a code.
- R5: `sof_o` pulses together with `delim_evt_o` on the first start code with bit 5 = 0 that follows one or more codes with bit 5 = 1, counting since reset or since the previous frame start.
- R6: After reset, `sol_o` stays low and no pixels are output until the first `sof_o`. A start code with bit 5 = 0 seen before that opens no line.
- R7: Once a frame has started, every start code with bit 5 = 0 pulses `sol_o` together with `delim_evt_o`, and this includes the line that carries `sof_o`. It also opens the active window.
- R8: While the window is open, each consumed byte that is not part of a reference code appears on `pix_data_o` with `pix_valid_o` high, in arrival order. It appears in the cycle after the edge that consumes the third byte following it. The preamble of the closing code is never output.
- R9: An end code closes the window, and so does any code with bit 5 = 1. Bytes between such a code and the next qualifying start code are dropped, and a start code with bit 5 = 1 opens nothing.
- R10: While reset is asserted, and in the first cycle after it is released, all outputs are 0.
- R11: A byte pattern in the window that only looks like a preamble, such as `FF 00 12` or `FF 00 00 10`, passes through as ordinary pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; bytes are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Byte enable; the byte on `data_i` is consumed when 1 |
| data_i | input | 8 | Incoming video byte |
| pix_data_o | output | 8 | Active-video byte; meaningful when `pix_valid_o` is 1 |
| pix_valid_o | output | 1 | One-cycle strobe marking a pixel byte |
| sol_o | output | 1 | Start-of-line pulse |
| sof_o | output | 1 | Start-of-frame pulse |
| delim_evt_o | output | 1 | One-cycle pulse for each recognised reference code |

## Verification
A matcher stuck in the wrong state either misses a code, so `delim_evt_o` is absent the cycle after the status byte, or invents one inside a line, which cuts the pixel run short. Either fault shows at the ports within one consumed byte. A wrong window or lock flag shows at once as pixels leaking from blanking or lines lost after the frame start. A wrong kill or shift in the three-stage delay corrupts the data or valid pattern three consumed bytes later. The bench's behavioural model compares every output on every clock, so each of these shows up within a handful of cycles.

// File: rtl/evd_pkg.sv
package evd_pkg;

  // Byte width of the video stream
  localparam int unsigned BYTE_W   = 8;
  // Reference code length in bytes and the preamble part of it
  localparam int unsigned CODE_LEN = 4;
  localparam int unsigned PRE_LEN  = CODE_LEN - 1;

  // Matcher progress through the preamble
  typedef enum logic [1:0] {
    M_HUNT  = 2'd0,
    M_LEAD  = 2'd1,
    M_ZERO1 = 2'd2,
    M_ZERO2 = 2'd3
  } match_st_e;

  // Decoded fields of the status byte that drive timing
  typedef struct packed {
    logic vblank;
    logic is_end;
  } code_info_t;

endpackage

// File: rtl/evd_code_matcher.sv
module evd_code_matcher
  import evd_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output code_info_t        info_o
);

  localparam logic [DATA_W-1:0] LEAD_B = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZERO_B = '0;
  localparam int unsigned       MARK_B = DATA_W - 1;
  localparam int unsigned       VBL_B  = DATA_W - 3;
  localparam int unsigned       END_B  = DATA_W - 4;

  match_st_e st_q, st_d;
  logic      hit_raw;

  always_comb begin
    st_d    = st_q;
    hit_raw = 1'b0;
    case (st_q)
      M_HUNT: begin
        if (data_i == LEAD_B) st_d = M_LEAD;
      end
      M_LEAD: begin
        if (data_i == ZERO_B)      st_d = M_ZERO1;
        else if (data_i == LEAD_B) st_d = M_LEAD;
        else                       st_d = M_HUNT;
      end
      M_ZERO1: begin
        if (data_i == ZERO_B)      st_d = M_ZERO2;
        else if (data_i == LEAD_B) st_d = M_LEAD;
        else                       st_d = M_HUNT;
      end
      M_ZERO2: begin
        // Any byte ends the code attempt; a marked byte completes it.
        // A lead byte always carries the mark, so it is a status, not a restart.
        st_d    = M_HUNT;
        hit_raw = data_i[MARK_B];
      end
      default: st_d = M_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= M_HUNT;
    end else if (en_i) begin
      st_q <= st_d;
    end
  end

  assign hit_o         = en_i & hit_raw;
  assign info_o.vblank = data_i[VBL_B];
  assign info_o.is_end = data_i[END_B];

endmodule

// File: rtl/evd_sync_tracker.sv
module evd_sync_tracker
  import evd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       hit_i,
  input  code_info_t info_i,
  output logic       win_o,
  output logic       sof_o,
  output logic       sol_o,
  output logic       evt_o
);

  logic locked_q, locked_d;
  logic blank_q,  blank_d;
  logic win_q,    win_d;
  logic sof_q,    sof_d;
  logic sol_q,    sol_d;
  logic evt_q,    evt_d;

  always_comb begin
    locked_d = locked_q;
    blank_d  = blank_q;
    win_d    = win_q;
    sof_d    = 1'b0;
    sol_d    = 1'b0;
    evt_d    = 1'b0;
    if (en_i && hit_i) begin
      evt_d = 1'b1;
      if (info_i.vblank) begin
        blank_d = 1'b1;
        win_d   = 1'b0;
      end else if (info_i.is_end) begin
        win_d   = 1'b0;
      end else begin
        if (blank_q) begin
          sof_d    = 1'b1;
          locked_d = 1'b1;
          blank_d  = 1'b0;
        end
        if (blank_q || locked_q) begin
          win_d = 1'b1;
          sol_d = 1'b1;
        end
      end
    end
  end

  // Timing state advances only on consumed bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      blank_q  <= 1'b0;
      win_q    <= 1'b0;
    end else if (en_i) begin
      locked_q <= locked_d;
      blank_q  <= blank_d;
      win_q    <= win_d;
    end
  end

  // Pulses are refreshed every cycle so they last a single cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_q <= 1'b0;
      sol_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      sof_q <= sof_d;
      sol_q <= sol_d;
      evt_q <= evt_d;
    end
  end

  assign win_o = win_q;
  assign sof_o = sof_q;
  assign sol_o = sol_q;
  assign evt_o = evt_q;

endmodule

// File: rtl/evd_pixel_delay.sv
module evd_pixel_delay
  import evd_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DEPTH  = PRE_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              keep_i,
  input  logic              kill_i,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pix_valid_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DATA_W-1:0] stg_d_q [DEPTH];
  logic              stg_v_q [DEPTH];
  logic [DATA_W-1:0] stg_d_n [DEPTH];
  logic              stg_v_n [DEPTH];
  logic [DATA_W-1:0] out_d_q;
  logic              out_v_q, out_v_n;

  // Stage inputs: the newest byte enters stage 0; a completed code
  // clears the valid flags of the preamble bytes held in the stages.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stg_d_n[g] = data_i;
      assign stg_v_n[g] = keep_i;
    end else begin : g_body
      assign stg_d_n[g] = stg_d_q[g-1];
      assign stg_v_n[g] = stg_v_q[g-1] & ~kill_i;
    end
  end

  assign out_v_n = en_i & stg_v_q[LAST] & ~kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_v_q[i] <= 1'b0;
    end else if (en_i) begin
      for (int i = 0; i < DEPTH; i++) stg_v_q[i] <= stg_v_n[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      for (int i = 0; i < DEPTH; i++) stg_d_q[i] <= stg_d_n[i];
      out_d_q <= stg_d_q[LAST];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
    end else begin
      out_v_q <= out_v_n;
    end
  end

  assign pix_data_o  = out_d_q;
  assign pix_valid_o = out_v_q;

endmodule

// File: rtl/evd_stream_decoder.sv
module evd_stream_decoder
  import evd_pkg::*;
#(
  parameter int unsigned DATA_W     = BYTE_W,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pix_valid_o,
  output logic              sol_o,
  output logic              sof_o,
  output logic              delim_evt_o
);

  localparam int unsigned DLY_DEPTH = CODE_LEN - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGE-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGE-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGE-1];

  logic       code_hit;
  code_info_t code_info;
  logic       win_open;
  logic       keep_byte;

  evd_code_matcher #(
    .DATA_W (DATA_W)
  ) u_matcher (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .data_i (data_i),
    .hit_o  (code_hit),
    .info_o (code_info)
  );

  evd_sync_tracker u_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .hit_i  (code_hit),
    .info_i (code_info),
    .win_o  (win_open),
    .sof_o  (sof_o),
    .sol_o  (sol_o),
    .evt_o  (delim_evt_o)
  );

  assign keep_byte = win_open & ~code_hit;

  evd_pixel_delay #(
    .DATA_W (DATA_W),
    .DEPTH  (DLY_DEPTH)
  ) u_delay (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .en_i        (en_i),
    .data_i      (data_i),
    .keep_i      (keep_byte),
    .kill_i      (code_hit),
    .pix_data_o  (pix_data_o),
    .pix_valid_o (pix_valid_o)
  );

endmodule

// File: rtl/evd_stream_decoder_chk.sv
module evd_stream_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic hit_i,
  input logic vblank_i,
  input logic pix_valid_i,
  input logic sol_i,
  input logic sof_i,
  input logic evt_i
);

  logic seen_sof_q;
  logic blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_sof_q <= 1'b0;
      blank_q    <= 1'b0;
    end else begin
      if (sof_i) seen_sof_q <= 1'b1;
      if (en_i && hit_i && vblank_i) blank_q <= 1'b1;
      else if (sof_i)                blank_q <= 1'b0;
    end
  end

  p_idle_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (!pix_valid_i && !sol_i && !sof_i && !evt_i));

  p_evt_after_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && hit_i) |-> evt_i);

  p_evt_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !evt_i);

  p_sof_needs_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> blank_q);

  p_no_pix_before_sof_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i || sol_i) |-> (seen_sof_q || sof_i));

  p_sof_opens_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> sol_i);

  p_sol_on_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |-> evt_i);

endmodule

bind evd_stream_decoder evd_stream_decoder_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .en_i        (en_i),
  .hit_i       (code_hit),
  .vblank_i    (code_info.vblank),
  .pix_valid_i (pix_valid_o),
  .sol_i       (sol_o),
  .sof_i       (sof_o),
  .evt_i       (delim_evt_o)
);

// File: tb/evd_stream_decoder_tb_top.sv
module evd_stream_decoder_tb_top;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [7:0] data;
  logic [7:0] pix_data;
  logic       pix_valid, sol, sof, evt;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  evd_stream_decoder dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .data_i      (data),
    .pix_data_o  (pix_data),
    .pix_valid_o (pix_valid),
    .sol_o       (sol),
    .sof_o       (sof),
    .delim_evt_o (evt)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model state
  typedef struct { logic [7:0] d; bit v; } slot_t;
  slot_t pq[$];
  int    p1 = 0, p2 = 0, p3 = 0, since_code = 0;
  bit    m_locked = 0, m_blank = 0, m_win = 0;
  bit    x_pv = 0, x_sol = 0, x_sof = 0, x_evt = 0, x_off = 0;
  logic [7:0] x_pd = 8'h00;

  // Phase counters from the DUT outputs
  int c_pix = 0, c_sol = 0, c_sof = 0, c_evt = 0;

  logic [15:0] lfsr = 16'hACE1;
  bit          gaps = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (pix_valid) c_pix++;
    if (sol) c_sol++;
    if (sof) c_sof++;
    if (evt) c_evt++;
    check(evt == x_evt, "R3 delim_evt", evt, x_evt);
    check(sof == x_sof, "R5 sof", sof, x_sof);
    check(sol == x_sol, "R7 sol", sol, x_sol);
    check(pix_valid == x_pv, "R8 pix_valid", pix_valid, x_pv);
    if (x_pv) check(pix_data == x_pd, "R8 pix_data", pix_data, x_pd);
    if (x_off)
      check({pix_valid, sol, sof, evt} == 4'b0, "R1 idle outputs",
            {pix_valid, sol, sof, evt}, 0);
  endtask

  task automatic model_step(input bit e, input logic [7:0] d);
    bit    hit;
    slot_t s, o;
    x_sol = 0; x_sof = 0; x_evt = 0; x_pv = 0;
    x_off = !e;
    if (!e) return;
    hit = (since_code >= 3) && (p3 == 8'hFF) && (p2 == 0) && (p1 == 0) && d[7];
    if (hit) begin
      for (int k = 1; k <= 3; k++)
        if (pq.size() >= k) pq[pq.size()-k].v = 0;
    end
    s.d = d; s.v = m_win && !hit;
    pq.push_back(s);
    if (pq.size() > 3) begin
      o = pq.pop_front();
      x_pv = o.v; x_pd = o.d;
    end
    if (hit) begin
      x_evt = 1;
      if (d[5]) begin
        m_blank = 1; m_win = 0;
      end else if (d[4]) begin
        m_win = 0;
      end else begin
        if (m_blank) begin
          x_sof = 1; m_locked = 1; m_blank = 0;
        end
        if (m_locked) begin
          m_win = 1; x_sol = 1;
        end
      end
    end
    p3 = p2; p2 = p1; p1 = d;
    since_code = hit ? 0 : (since_code < 3 ? since_code + 1 : 3);
  endtask

  task automatic cyc(input bit e, input logic [7:0] d);
    @(negedge clk);
    compare();
    en   = e;
    data = d;
    model_step(e, d);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic send(input logic [7:0] b);
    step_lfsr();
    if (gaps && lfsr[1:0] == 2'b00) cyc(0, 8'h5A);
    cyc(1, b);
  endtask

  task automatic send_code(input logic [7:0] st);
    send(8'hFF); send(8'h00); send(8'h00); send(st);
  endtask

  task automatic phase_start();
    c_pix = 0; c_sol = 0; c_sof = 0; c_evt = 0;
  endtask

  task automatic phase_end(input string tag, input int pix, input int sl, input int sf, input int ev);
    cyc(0, 8'h00);
    check(c_pix == pix, {tag, " pixel count"}, c_pix, pix);
    check(c_sol == sl,  {tag, " line starts"}, c_sol, sl);
    check(c_sof == sf,  {tag, " frame starts"}, c_sof, sf);
    check(c_evt == ev,  {tag, " code events"}, c_evt, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; data = 8'h00;
    repeat (3) @(negedge clk);
    // R10: outputs low during reset
    check({pix_valid, sol, sof, evt} == 4'b0, "R10 reset outputs", {pix_valid, sol, sof, evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({pix_valid, sol, sof, evt} == 4'b0, "R10 after release", {pix_valid, sol, sof, evt}, 0);
    repeat (4) cyc(0, 8'h00);
    gaps = 1;

    // R6: start code before any blanking opens nothing
    phase_start();
    send_code(8'h80);
    for (int i = 0; i < 5; i++) send(8'h11 + 8'(i));
    send_code(8'h9D);
    phase_end("R6 prelock", 0, 0, 0, 2);

    // R9: blanking codes, start code with vblank set opens nothing
    phase_start();
    send_code(8'hB6);
    repeat (4) send(8'h10);
    send_code(8'hAB);
    repeat (6) send(8'h10);
    phase_end("R9 blanking", 0, 0, 0, 2);

    // R11 and R2: two active lines, lookalike patterns, field bit set on line 2
    phase_start();
    send_code(8'h80);
    send(8'h01); send(8'h02);
    send(8'hFF); send(8'h00); send(8'h12);
    send(8'hFF); send(8'h00); send(8'h00); send(8'h10);
    send(8'h33);
    send_code(8'h9D);
    repeat (4) send(8'h10);
    send_code(8'hC0);
    for (int i = 0; i < 6; i++) send(8'h40 + 8'(i));
    send_code(8'hDD);
    phase_end("R11 R2 active", 16, 2, 1, 4);

    // R4: restart on FF and rejected status byte; R9 when locked
    phase_start();
    send_code(8'hB6);
    send(8'h20);
    send(8'hFF); send_code(8'hAB);
    send(8'h20);
    send(8'hFF); send(8'h00); send(8'h00); send(8'h7F);
    send(8'h20); send(8'h20);
    phase_end("R4 R9 matcher", 0, 0, 0, 2);

    // R5: next frame after blanking
    phase_start();
    send_code(8'h80);
    for (int i = 0; i < 4; i++) send(8'h05 + 8'(i));
    send_code(8'h9D);
    phase_end("R5 frame", 4, 1, 1, 2);

    // Mixed stream, model compared every clock (R8)
    for (int ln = 0; ln < 60; ln++) begin
      step_lfsr();
      send_code(lfsr[3] ? 8'hB6 : 8'h9D);
      repeat (2 + lfsr[6:5]) send(8'h10);
      step_lfsr();
      send_code(lfsr[2:0] == 3'd0 ? 8'hAB : 8'h80);
      step_lfsr();
      for (int i = 0; i < 4 + int'(lfsr[3:0]); i++) begin
        step_lfsr();
        send(lfsr[4] ? lfsr[15:8] : {6'd0, lfsr[1:0]} * 8'h7F);
      end
    end
    repeat (6) cyc(1, 8'h10);
    cyc(0, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule